// File: doc/BRIEF.md
# Reloading Down-Counter Toggle Timer Channel

This block is a single timer channel that serves as an interval timer and as a frequency divider. Software writes a period value, picks one of two incoming prescaled count-clock enables, and writes a start trigger. From then on a 16-bit down counter steps only on the chosen count-clock pulse. Each time it wraps, it raises a one-cycle interrupt pulse and flips a waveform output. The resulting output period is 2 × (period + 1) count clocks.

The first count-clock pulse after a start loads the period instead of decrementing. A mode bit decides whether that first load also counts as an event. A stop trigger freezes the counter value and the output level where they are. An output-enable gate chooses who drives the waveform pin: the level that software wrote, or the timer. A global unit enable held low clears the whole channel. The register interface is a plain synchronous write strobe with a combinational read mux.

Register map (3-bit address, 16-bit data):
- Address 0: period, read/write.
- Address 1: counter, read-only.
- Address 2: control. Bit 0 is start, bit 1 is stop, bit 2 is the run flag (read-only).
- Address 3: mode. Bit 0 selects the count clock (0 = `cke0_i`, 1 = `cke1_i`). Bit 1 makes the start load fire an event. Bit 2 inverts the output.
- Address 4: output. Bit 0 is the level, bit 1 is the output enable.
- Unused addresses and unused bits read as 0.

Top module: `tmr_channel`

## Requirements
- R1: Writing 1 to control bit 0 sets the run flag (control bit 2). Control bits 0 and 1 always read 0.
- R2: On the first selected count-clock pulse after a start, the counter takes the period value instead of decrementing. If mode bit 1 is 1, that load also pulses `irq_o` for one cycle and toggles the output level. If mode bit 1 is 0, neither happens.
- R3: While running, each selected count-clock pulse decrements the counter. A pulse that finds the counter at 0 reloads the period, pulses `irq_o` and toggles the level. A period of 0 therefore produces an event on every count clock.
- R4: With mode bit 0 at 0 only `cke0_i` advances the counter, and with mode bit 0 at 1 only `cke1_i` does.
- R5: A period written while running takes effect at the next reload. The count already in progress is not disturbed.
- R6: Writing 1 to control bit 1 clears the run flag. The counter and the output level then hold. If bits 0 and 1 are written together, the stop wins.
- R7: A start written while running restarts the channel: the next count-clock pulse loads the period again.
- R8: Output bit 0 sets the level only when the current output enable is 0. With the output enable at 0, events do not toggle the level. `tout_o` equals the level XOR mode bit 2.
- R9: Writes to the mode register are ignored while the run flag is 1.
- R10: When `unit_en_i` is 0, every register, the counter, the level and the run flag clear to 0 and stay there, and bus writes have no effect.
- R11: The counter can be read at address 1 at any time, including while the channel runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_en_i | input | 1 | Global unit enable; 0 clears the channel |
| cke0_i | input | 1 | Prescaled count-clock enable 0 |
| cke1_i | input | 1 | Prescaled count-clock enable 1 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| run_o | output | 1 | Run flag |
| irq_o | output | 1 | One-cycle interrupt pulse |
| tout_o | output | 1 | Waveform output |

## Verification
The bench runs the start load with and without the start-event bit. A design that decremented on that first pulse, or fired regardless of the bit, would show a counter one short or an extra interrupt.

It rewrites the period mid-count, restarts a running channel, and writes start together with stop. Wrong handling shows up as a disturbed count in progress, a missing reload, or a channel left running.

With period 0 it checks that every count clock produces an event. It also drives the unselected count enable, which a design that ignored the select bit would count.

It writes the level while the output enable is set, writes the mode register while running, and drops the unit enable. A faulty design would move the output pin, change the mode, or keep stale state.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PERIOD = 3'd0,
        SEL_COUNT  = 3'd1,
        SEL_CTRL   = 3'd2,
        SEL_MODE   = 3'd3,
        SEL_OUT    = 3'd4
    } reg_sel_e;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_STOP_BIT  = 1;
    localparam int CTRL_RUN_BIT   = 2;
    localparam int OUT_LVL_BIT    = 0;
    localparam int OUT_OE_BIT     = 1;
    localparam int MODE_W         = 3;

    typedef struct packed {
        logic invert;
        logic start_irq;
        logic clk_sel;
    } mode_t;

    typedef enum logic [1:0] {
        TRIG_NONE  = 2'd0,
        TRIG_START = 2'd1,
        TRIG_STOP  = 2'd2
    } trig_e;

    function automatic trig_e decode_trig(logic start_b, logic stop_b);
        if (stop_b)       return TRIG_STOP;
        else if (start_b) return TRIG_START;
        else              return TRIG_NONE;
    endfunction

    function automatic logic pick_tick(mode_t m, logic c0, logic c1);
        return m.clk_sel ? c1 : c0;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              run,
    output logic [CNT_W-1:0]  period_q,
    output mode_t             mode_q,
    output logic              oe_q,
    output trig_e             trig,
    output logic              lvl_wr,
    output logic              lvl_wdata
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (clr) begin
            period_q <= '0;
            mode_q   <= '0;
            oe_q     <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_PERIOD: period_q <= wdata;
                SEL_MODE: begin
                    if (!run) mode_q <= mode_t'(wdata[MODE_W-1:0]);
                end
                SEL_OUT: oe_q <= wdata[OUT_OE_BIT];
                default: ;
            endcase
        end
    end

    always_comb begin
        trig      = TRIG_NONE;
        lvl_wr    = 1'b0;
        lvl_wdata = wdata[OUT_LVL_BIT];
        if (wr_en && sel == SEL_CTRL)
            trig = decode_trig(wdata[CTRL_START_BIT], wdata[CTRL_STOP_BIT]);
        if (wr_en && sel == SEL_OUT && !oe_q)
            lvl_wr = 1'b1;
    end

    // R9: mode holds while the channel was running
    a_r9_mode_locked: assert property (@(posedge clk) disable iff (clr)
        ($past(run) && !$past(clr)) |-> $stable(mode_q));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  trig_e            trig,
    input  logic             tick,
    input  logic             start_irq,
    input  logic [CNT_W-1:0] period,
    output logic             run_q,
    output logic [CNT_W-1:0] count_q,
    output logic             fire,
    output logic             irq_q
);

    logic pend_q;
    logic step;
    logic at_zero;

    assign at_zero = (count_q == '0);
    assign step    = (trig == TRIG_NONE) && run_q && tick;
    assign fire    = step && (pend_q ? start_irq : at_zero);

    always_ff @(posedge clk) begin
        if (clr) begin
            run_q   <= 1'b0;
            pend_q  <= 1'b0;
            count_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= fire;
            case (trig)
                TRIG_STOP: begin
                    run_q  <= 1'b0;
                    pend_q <= 1'b0;
                end
                TRIG_START: begin
                    run_q  <= 1'b1;
                    pend_q <= 1'b1;
                end
                default: begin
                    if (step) begin
                        if (pend_q) begin
                            count_q <= period;
                            pend_q  <= 1'b0;
                        end else if (at_zero) begin
                            count_q <= period;
                        end else begin
                            count_q <= count_q - 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R6: a stopped channel keeps its count
    a_r6_frozen_count: assert property (@(posedge clk) disable iff (clr)
        ($past(!run_q) && !$past(clr)) |-> $stable(count_q));

    // R3: interrupts only come from a running channel
    a_r3_irq_needs_run: assert property (@(posedge clk) disable iff (clr)
        irq_q |-> $past(run_q));

    // R2: the first step after a start loads the period
    a_r2_start_load: assert property (@(posedge clk) disable iff (clr)
        ($past(step && pend_q) && !$past(clr)) |-> (count_q == $past(period)));

endmodule

// File: rtl/tmr_wave.sv
module tmr_wave (
    input  logic clk,
    input  logic clr,
    input  logic oe,
    input  logic invert,
    input  logic lvl_wr,
    input  logic lvl_wdata,
    input  logic fire,
    output logic level_q,
    output logic tout
);

    always_ff @(posedge clk) begin
        if (clr)
            level_q <= 1'b0;
        else if (lvl_wr)
            level_q <= lvl_wdata;
        else if (oe && fire)
            level_q <= ~level_q;
    end

    assign tout = level_q ^ invert;

    // R8: a software write to the level never coincides with the timer driving it
    a_r8_write_gated: assert property (@(posedge clk) disable iff (clr)
        lvl_wr |-> !oe);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              unit_en_i,
    input  logic              cke0_i,
    input  logic              cke1_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              run_o,
    output logic              irq_o,
    output logic              tout_o
);

    logic             clr;
    logic             wr_g;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] count_q;
    mode_t            mode_q;
    logic             oe_q;
    trig_e            trig;
    logic             lvl_wr;
    logic             lvl_wdata;
    logic             tick;
    logic             fire;
    logic             level_q;

    assign clr  = rst | ~unit_en_i;
    assign wr_g = wr_en_i & unit_en_i;
    assign tick = pick_tick(mode_q, cke0_i, cke1_i);

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .clr       (clr),
        .wr_en     (wr_g),
        .addr      (addr_i),
        .wdata     (wdata_i),
        .run       (run_o),
        .period_q  (period_q),
        .mode_q    (mode_q),
        .oe_q      (oe_q),
        .trig      (trig),
        .lvl_wr    (lvl_wr),
        .lvl_wdata (lvl_wdata)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .clr       (clr),
        .trig      (trig),
        .tick      (tick),
        .start_irq (mode_q.start_irq),
        .period    (period_q),
        .run_q     (run_o),
        .count_q   (count_q),
        .fire      (fire),
        .irq_q     (irq_o)
    );

    tmr_wave u_wave (
        .clk       (clk),
        .clr       (clr),
        .oe        (oe_q),
        .invert    (mode_q.invert),
        .lvl_wr    (lvl_wr),
        .lvl_wdata (lvl_wdata),
        .fire      (fire),
        .level_q   (level_q),
        .tout      (tout_o)
    );

    always_comb begin
        rdata_o = '0;
        case (reg_sel_e'(addr_i))
            SEL_PERIOD: rdata_o = period_q;
            SEL_COUNT:  rdata_o = count_q;
            SEL_CTRL:   rdata_o[CTRL_RUN_BIT] = run_o;
            SEL_MODE:   rdata_o[MODE_W-1:0] = mode_q;
            SEL_OUT: begin
                rdata_o[OUT_LVL_BIT] = level_q;
                rdata_o[OUT_OE_BIT]  = oe_q;
            end
            default: ;
        endcase
    end

    // R1: a start trigger leaves the run flag set
    a_r1_start_sets_run: assert property (@(posedge clk) disable iff (clr)
        ($past(trig == TRIG_START) && !$past(clr)) |-> run_o);

    // R8: with the gate open, the level moves exactly when an interrupt fires
    a_r8_toggle_on_irq: assert property (@(posedge clk) disable iff (clr)
        ($past(oe_q) && !$past(lvl_wr) && !$past(clr)) |-> ((level_q != $past(level_q)) == irq_o));

endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        unit_en = 1'b1;
    logic        cke0 = 1'b0;
    logic        cke1 = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        run;
    logic        irq;
    logic        tout;

    tmr_channel u_dut (
        .clk       (clk),
        .rst       (rst),
        .unit_en_i (unit_en),
        .cke0_i    (cke0),
        .cke1_i    (cke1),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .run_o     (run),
        .irq_o     (irq),
        .tout_o    (tout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    kind;
        int    exp;
        string tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    fails  = 0;
    int    irq_cnt = 0;
    bit    done = 1'b0;

    always @(negedge clk) begin
        int act;
        if (irq) irq_cnt++;
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = int'(rdata);
                1:       act = irq_cnt;
                default: act = int'(tout);
            endcase
            checks++;
            if (act != it.exp) begin
                fails++;
                $display("FAIL %s actual %0d expected %0d", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(int kind, int exp, string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic rd(logic [2:0] a, int exp, string tag);
        @(posedge clk);
        #1;
        addr = a;
        push(0, exp, tag);
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(posedge clk);
        #1;
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic tick(bit sel);
        @(posedge clk);
        #1;
        if (sel) cke1 = 1'b1; else cke0 = 1'b1;
        @(posedge clk);
        #1;
        cke0 = 1'b0;
        cke1 = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R10 reset state
        rd(3'd0, 0, "R10 period after reset");
        rd(3'd1, 0, "R10 count after reset");
        rd(3'd2, 0, "R10 ctrl after reset");
        rd(3'd4, 0, "R10 out after reset");
        push(2, 0, "R10 tout after reset");

        // R1 / R2 / R3: period 3, start event on, cke0
        wr(3'd0, 16'd3);
        wr(3'd3, 16'h0002);
        wr(3'd4, 16'h0002);
        wr(3'd2, 16'h0001);
        rd(3'd2, 4, "R1 run set, triggers read 0");
        tick(0);
        rd(3'd1, 3, "R2 first tick loads period");
        push(1, 1, "R2 start event irq");
        push(2, 1, "R2 start event toggles");
        tick(0);
        rd(3'd1, 2, "R11 count readable while running");
        tick(0);
        tick(0);
        rd(3'd1, 0, "R3 counted down to zero");
        push(1, 1, "R3 no irq before wrap");
        tick(0);
        rd(3'd1, 3, "R3 reload at zero");
        push(1, 2, "R3 irq on wrap");
        push(2, 0, "R3 toggle on wrap");
        tick(1);
        rd(3'd1, 3, "R4 unselected enable ignored");

        // R5: rewrite period mid-count
        wr(3'd0, 16'd1);
        tick(0);
        rd(3'd1, 2, "R5 count in progress undisturbed");
        tick(0);
        tick(0);
        tick(0);
        rd(3'd1, 1, "R5 new period at reload");
        push(1, 3, "R5 irq at reload");
        push(2, 1, "R5 toggle at reload");

        // R9 locked mode
        wr(3'd3, 16'h0001);
        rd(3'd3, 2, "R9 mode write ignored while running");

        // R6 stop holds
        wr(3'd2, 16'h0002);
        rd(3'd2, 0, "R6 stop clears run");
        tick(0);
        tick(0);
        rd(3'd1, 1, "R6 count held");
        push(1, 3, "R6 no irq when stopped");
        push(2, 1, "R6 output held");

        // R2 without start event, cke1
        wr(3'd3, 16'h0001);
        rd(3'd3, 1, "R9 mode writable when stopped");
        wr(3'd0, 16'd2);
        wr(3'd2, 16'h0001);
        tick(1);
        rd(3'd1, 2, "R2 load with start event off");
        push(1, 3, "R2 no irq at start when bit clear");
        push(2, 1, "R2 no toggle at start when bit clear");
        tick(0);
        rd(3'd1, 2, "R4 cke0 ignored when cke1 selected");
        tick(1);
        rd(3'd1, 1, "R4 cke1 counts");

        // R7 restart
        wr(3'd2, 16'h0001);
        tick(1);
        rd(3'd1, 2, "R7 restart reloads");

        // R6 stop wins
        wr(3'd2, 16'h0003);
        rd(3'd2, 0, "R6 stop wins over start");
        tick(1);
        rd(3'd1, 2, "R6 count held after combined trigger");

        // R8 forced level
        wr(3'd4, 16'h0000);
        push(2, 1, "R8 level write ignored while gate was on");
        wr(3'd4, 16'h0000);
        push(2, 0, "R8 level forced low");
        wr(3'd4, 16'h0001);
        push(2, 1, "R8 level forced high");
        wr(3'd4, 16'h0000);

        // R3 period 0, R8 gate off blocks toggle
        wr(3'd0, 16'd0);
        wr(3'd2, 16'h0001);
        tick(1);
        tick(1);
        push(1, 4, "R3 period 0 event");
        push(2, 0, "R8 no toggle with gate off");
        wr(3'd4, 16'h0002);
        tick(1);
        push(1, 5, "R3 period 0 every tick");
        push(2, 1, "R8 timer drives with gate on");
        tick(1);
        push(1, 6, "R3 period 0 next tick");
        push(2, 0, "R3 period 0 toggles each tick");
        wr(3'd4, 16'h0003);
        rd(3'd4, 2, "R8 level write ignored with gate on");

        // R8 inversion
        wr(3'd2, 16'h0002);
        wr(3'd3, 16'h0005);
        rd(3'd3, 5, "R9 mode accepted after stop");
        push(2, 1, "R8 inverted output");

        // R10 unit disable
        @(posedge clk);
        #1;
        unit_en = 1'b0;
        wr(3'd0, 16'd5);
        rd(3'd0, 0, "R10 period cleared, write ignored");
        rd(3'd3, 0, "R10 mode cleared");
        rd(3'd4, 0, "R10 level cleared");
        push(2, 0, "R10 output cleared");
        @(posedge clk);
        #1;
        unit_en = 1'b1;
        rd(3'd0, 0, "R10 period stays cleared");
        rd(3'd2, 0, "R10 run cleared");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule